// File: doc/BRIEF.md
# Down-Spread Triangle Offset Generator

This block generates the frequency-offset sequence for spread-spectrum clocking. It drives the fractional divider of each clock output whose reference is the internal PLL. One shared up/down accumulator traces a symmetric triangle. A prescaler derived from the reference frequency, the target modulation rate and the number of steps per slope sets its step timing. The step size comes from a 3-bit depth code. Each output lane turns the triangle magnitude into a non-positive signed offset word. The offset is expressed in units of 2^-FRAC_W of the nominal divider value, so the output frequency only moves below nominal.

Each lane is eligible for spreading only when its mask bit is set and its source is not the voltage-controlled oscillator. A lane loads a new offset word only when its divider reports a cycle boundary on its update strobe. Between strobes the word is held. The global spread enable is sampled synchronously. When it drops, the triangle winds down to zero at the normal slope and then stays there. When it returns, a fresh triangle starts from zero.

With the default parameters (25 MHz reference, 31.5 kHz rate, 32 steps per slope) the tick period is 12 cycles. A full triangle is 64 ticks, about 32.5 kHz at 25 MHz.

Top module: `ssc_profile_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, every offset word is zero and the triangle magnitude is zero.
- R2: No offset word is ever positive. The magnitude never exceeds the peak of the 2.5% depth setting.
- R3: The depth code k = 0..4 selects depth (k+1)*0.5%. The step is floor((k+1)*2^FRAC_W/(200*STEPS)) and the peak is STEPS times the step. Codes 5, 6 and 7 behave exactly like code 0.
- R4: The magnitude changes only on a tick. A tick occurs once every TICK_DIV = REF_HZ/(RATE_HZ*2*STEPS) cycles, with a minimum of 1. The first tick comes TICK_DIV cycles after reset release.
- R5: While enabled, each tick raises the magnitude by one step until it reaches or would pass the current peak, where it saturates and turns. It then falls by one step per tick until it reaches or would pass zero, where it saturates and turns up again.
- R6: A lane whose source-select bit is 1 (sourced from the voltage-controlled oscillator) always loads a zero offset, whatever its mask bit.
- R7: A lane whose mask bit is 0 always loads a zero offset.
- R8: While the spread enable is low, each tick lowers the magnitude by one step, saturating at zero. It then stays at zero. Eligible lanes keep following this wind-down.
- R9: When the enable rises, the magnitude keeps falling until it reaches zero and then starts a new rising slope.
- R10: A lane's offset word changes only in the cycle after its update strobe is high. Otherwise it holds its value.
- R11: At a strobe, an eligible lane loads the negated magnitude present in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ssc_en_i | input | 1 | Global spread enable, high to spread |
| depth_code_i | input | 3 | Spread depth selection |
| spread_mask_i | input | NUM_OUT | Per-lane spread request |
| src_vcxo_i | input | NUM_OUT | Per-lane source, 1 = voltage-controlled oscillator |
| upd_i | input | NUM_OUT | Per-lane divider-cycle-boundary strobe |
| ofs_o | output | NUM_OUT*OFS_W | Signed offset words, lane i at bits [i*OFS_W +: OFS_W] |

## Verification
A corrupted accumulator shows up on every eligible lane at its next strobe. With strobes every cycle, that is within one tick period, 12 cycles by default. A miscounting prescaler moves the cycle in which the lane words change, so it is caught at the first misplaced tick. A wrong step or peak appears as a mismatch against the per-cycle reference model and as a wrong extreme of the triangle. A faulty eligibility or hold path shows as a non-zero or changed word on a lane that should be zero or frozen, in the cycle after the strobe.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} ssc_dir_e;

  // step = floor(depth_halfpct * 2^frac_w / (200 * steps)); unused codes fold to 0.5%
  function automatic int unsigned ssc_step(input logic [2:0] code, input int unsigned frac_w,
                                           input int unsigned steps);
    longint unsigned k;
    longint unsigned num;
    k   = (code <= 3'd4) ? (64'(code) + 64'd1) : 64'd1;
    num = k << frac_w;
    return 32'(num / (64'd200 * 64'(steps)));
  endfunction
endpackage

// File: rtl/ssc_tick_gen.sv
module ssc_tick_gen #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < DIV); // R4
endmodule

// File: rtl/ssc_tri_acc.sv
module ssc_tri_acc
  import ssc_pkg::*;
#(
  parameter int unsigned MAG_W  = 23,
  parameter int unsigned STEPS  = 32,
  parameter int unsigned FRAC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [2:0]       code_i,
  output logic [MAG_W-1:0] mag_o
);
  localparam int unsigned PEAK_MAX = ssc_step(3'd4, FRAC_W, STEPS) * STEPS;

  logic [MAG_W-1:0] mag_q;
  ssc_dir_e         dir_q;
  logic [31:0]      step_c, peak_c, mag32;

  assign step_c = ssc_step(code_i, FRAC_W, STEPS);
  assign peak_c = step_c * STEPS;
  assign mag32  = 32'(mag_q);
  assign mag_o  = mag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick_i) begin
      if (en_i && dir_q == DIR_UP) begin
        if (mag32 + step_c >= peak_c) begin
          mag_q <= MAG_W'(peak_c);
          dir_q <= DIR_DN;
        end else begin
          mag_q <= MAG_W'(mag32 + step_c);
        end
      end else begin
        // falling slope, or wind-down while disabled
        if (mag32 <= step_c) begin
          mag_q <= '0;
          dir_q <= DIR_UP;
        end else begin
          mag_q <= MAG_W'(mag32 - step_c);
          dir_q <= DIR_DN;
        end
      end
    end
  end

  AST_MAG_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(mag_q) <= PEAK_MAX); // R2
  AST_FLAT_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(mag_q)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && mag_q == '0) |=> mag_q == '0); // R8
  AST_WIND_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && tick_i && mag_q != '0) |=> mag_q < $past(mag_q)); // R8
endmodule

// File: rtl/ssc_out_lane.sv
module ssc_out_lane #(
  parameter int unsigned OFS_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic                    elig_i,
  input  logic [OFS_W-2:0]        mag_i,
  output logic signed [OFS_W-1:0] ofs_o
);
  logic signed [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ofs_q <= '0;
    else if (upd_i) ofs_q <= elig_i ? -$signed({1'b0, mag_i}) : '0;
  end

  assign ofs_o = ofs_q;

  AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(ofs_q)); // R10
  AST_NEG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_q[OFS_W-1] || ofs_q == '0); // R2
  AST_INELIG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !elig_i) |=> ofs_q == '0); // R7
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int unsigned REF_HZ  = 25_000_000,
  parameter int unsigned RATE_HZ = 31_500,
  parameter int unsigned STEPS   = 32,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned OFS_W   = FRAC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ssc_en_i,
  input  logic [2:0]                 depth_code_i,
  input  logic [NUM_OUT-1:0]         spread_mask_i,
  input  logic [NUM_OUT-1:0]         src_vcxo_i,
  input  logic [NUM_OUT-1:0]         upd_i,
  output logic [NUM_OUT*OFS_W-1:0]   ofs_o
);
  localparam int unsigned TICK_RAW = REF_HZ / (RATE_HZ * 2 * STEPS);
  localparam int unsigned TICK_DIV = (TICK_RAW == 0) ? 1 : TICK_RAW;
  localparam int unsigned MAG_W    = OFS_W - 1;

  logic             tick;
  logic [MAG_W-1:0] mag;
  logic [NUM_OUT-1:0] elig;

  assign elig = spread_mask_i & ~src_vcxo_i;

  ssc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ssc_tri_acc #(.MAG_W(MAG_W), .STEPS(STEPS), .FRAC_W(FRAC_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .en_i  (ssc_en_i),
    .code_i(depth_code_i),
    .mag_o (mag)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic signed [OFS_W-1:0] lane_ofs;

    ssc_out_lane #(.OFS_W(OFS_W)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .upd_i (upd_i[g]),
      .elig_i(elig[g]),
      .mag_i (mag),
      .ofs_o (lane_ofs)
    );

    assign ofs_o[g*OFS_W +: OFS_W] = lane_ofs;

    AST_VCXO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i[g] && src_vcxo_i[g]) |=> lane_ofs == '0); // R6
    AST_LANE_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i[g] && elig[g]) |=> lane_ofs == -$signed({1'b0, $past(mag)})); // R11
  end
endmodule

// File: tb/ssc_profile_gen_bench.sv
module ssc_profile_gen_bench;
  localparam int unsigned REF_HZ  = 25_000_000;
  localparam int unsigned RATE_HZ = 31_500;
  localparam int unsigned STEPS   = 32;
  localparam int unsigned FRAC_W  = 24;
  localparam int unsigned N       = 4;
  localparam int unsigned W       = FRAC_W;
  localparam longint TD = longint'(REF_HZ / (RATE_HZ * 2 * STEPS));

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ssc_en_i = 1'b0;
  logic [2:0] depth_code_i = 3'd0;
  logic [N-1:0] spread_mask_i = '0;
  logic [N-1:0] src_vcxo_i = '0;
  logic [N-1:0] upd_i = '0;
  logic [N*W-1:0] ofs_o;

  ssc_profile_gen u_ssc_profile_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .ssc_en_i(ssc_en_i), .depth_code_i(depth_code_i),
    .spread_mask_i(spread_mask_i), .src_vcxo_i(src_vcxo_i), .upd_i(upd_i), .ofs_o(ofs_o)
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  int checks = 0;
  int fails = 0;
  string ph = "R1";
  bit chk_on = 1'b0;

  function automatic longint stepf(input logic [2:0] c);
    longint k;
    k = (c <= 3'd4) ? longint'(c) + 1 : 1;
    return (k * (longint'(1) << FRAC_W)) / (200 * longint'(STEPS));
  endfunction

  function automatic longint lane(input int i);
    return longint'($signed(ofs_o[i*W +: W]));
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  longint m_cnt = 0, m_mag = 0;
  bit m_up = 1'b1;
  longint m_ofs [N];
  initial for (int i = 0; i < N; i++) m_ofs[i] = 0;

  always @(posedge clk_i) begin
    longint st, pk;
    if (!rst_ni) begin
      m_cnt = 0; m_mag = 0; m_up = 1'b1;
      for (int i = 0; i < N; i++) m_ofs[i] = 0;
    end else begin
      for (int i = 0; i < N; i++)
        if (upd_i[i]) m_ofs[i] = (spread_mask_i[i] && !src_vcxo_i[i]) ? -m_mag : 0;
      if (m_cnt == TD - 1) begin
        m_cnt = 0;
        st = stepf(depth_code_i);
        pk = st * STEPS;
        if (ssc_en_i && m_up) begin
          if (m_mag + st >= pk) begin m_mag = pk; m_up = 1'b0; end
          else m_mag = m_mag + st;
        end else begin
          if (m_mag <= st) begin m_mag = 0; m_up = 1'b1; end
          else begin m_mag = m_mag - st; m_up = 1'b0; end
        end
      end else m_cnt++;
    end
  end

  // per-cycle comparison, sampled away from the active edge
  longint min0 = 0;
  bit track_min = 1'b0;
  longint prev0 = 0, last_chg = -1, cyc = 0;
  bit chk_tick = 1'b0;

  always @(negedge clk_i) begin
    cyc++;
    if (chk_on) begin
      for (int i = 0; i < N; i++) begin
        string t;
        t = (i == 3) ? "R6" : (i == 2) ? "R7" : (i == 1 && ph != "R10") ? "R11" : ph;
        check(t, lane(i), m_ofs[i]);
      end
      if (track_min && lane(0) < min0) min0 = lane(0);
      if (chk_tick && lane(0) != prev0) begin
        if (last_chg >= 0) check("R4", cyc - last_chg, TD);
        last_chg = cyc;
      end
      prev0 = lane(0);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run(3);
    for (int i = 0; i < N; i++) check("R1", lane(i), 0);
    chk_on = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    spread_mask_i = 4'b1011;
    src_vcxo_i    = 4'b1000;
    upd_i         = 4'b1111;
    run(5);
    for (int i = 0; i < N; i++) check("R1", lane(i), 0);

    // nominal triangle, depth 0.5%
    ph = "R5"; ssc_en_i = 1'b1; depth_code_i = 3'd0;
    chk_tick = 1'b1; track_min = 1'b1; min0 = 0;
    run(2000);
    chk_tick = 1'b0;
    check("R3", min0, -stepf(3'd0) * STEPS);

    // deepest setting
    ph = "R3"; depth_code_i = 3'd4; min0 = 0;
    run(2000);
    check("R2", min0, -stepf(3'd4) * STEPS);

    // unused code folds to 0.5%
    depth_code_i = 3'd6; track_min = 1'b0;
    run(2000);
    min0 = 0; track_min = 1'b1;
    run(1000);
    check("R3", min0, -stepf(3'd0) * STEPS);

    // wind-down while disabled
    ph = "R8"; depth_code_i = 3'd2;
    run(300);
    ssc_en_i = 1'b0;
    run(2500);
    check("R8", lane(0), 0);
    check("R8", lane(1), 0);

    // re-enable, including mid wind-down
    ph = "R9"; ssc_en_i = 1'b1;
    run(500);
    ssc_en_i = 1'b0;
    run(40);
    ssc_en_i = 1'b1;
    run(1200);

    // sparse strobes
    ph = "R10";
    for (int c = 0; c < 1500; c++) begin
      upd_i = {c % 5 == 0, c % 3 == 0, c % 7 == 0, c % 2 == 0};
      @(negedge clk_i);
    end
    upd_i = '0;
    prev0 = lane(0);
    run(200);
    check("R10", lane(0), prev0);

    chk_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule